// File: doc/BRIEF.md
# Monitor Channel Message Transmitter

This block sends a message of one or more bytes over a frame-based monitor channel. A frame strobe marks each frame. On each strobe the block samples the receiver's active-low acknowledge bit, then updates the byte it presents and its active-low enable bit for the frame that begins. Bytes come from an upstream source through a ready/valid handshake, and a last-byte marker closes the message. The block ends each message with a one-cycle `done` pulse, or with a one-cycle `aborted` pulse if the receiver refuses a byte.

The controller has seven states. IDLE waits for a byte and for the acknowledge line to be quiet. FIRST holds the opening byte until the receiver pre-acknowledges it with a falling acknowledge. ADVANCE holds an accepted byte and moves on once the byte has been shown long enough. GAP is the single frame with enable raised that announces a following byte. HOLD presents that byte and waits for a rising acknowledge, which is the pre-acknowledge. CHECK decides between acknowledge and abort. ENDING is the extra inactive frame that closes the message.

The transitions are: IDLE→FIRST on an accepted byte; FIRST→ADVANCE on a falling acknowledge; ADVANCE→GAP on an accepted next byte; ADVANCE→ENDING when the held byte was marked last; GAP→HOLD after one frame; HOLD→CHECK on a rising acknowledge; CHECK→ADVANCE when acknowledge is low again; CHECK→IDLE when acknowledge stays high (abort); ENDING→IDLE with `done`. The presented byte goes out most significant bit first, so `mon_byte[7]` is the first bit a serializer places on the line.

Top module: `mon_tx`

## Requirements
- R1: After reset `en_n` is 1, `mon_byte` is all ones, and `in_ready`, `done` and `aborted` are 0. `in_ready` is 0 in every cycle where `frame_tick` is 0.
- R2: A message starts only on a frame tick where `ack_n` is sampled 1 and was also sampled 1 on the previous frame tick. In that same update `en_n` goes to 0 and the first byte appears on `mon_byte`.
- R3: Every byte stays on `mon_byte` for at least two frames, even when the receiver acknowledges after only one frame.
- R4: The first byte is released only after a falling `ack_n` (1 on the previous tick, 0 on this one). A later byte is released only after a rising `ack_n` followed by `ack_n` = 0 on the next tick. Until then the byte and `en_n` = 0 stay as they are.
- R5: A following byte is presented with `en_n` = 1 for exactly one frame, and `en_n` returns to 0 on the next frame with the same byte.
- R6: After the last byte has been released, `en_n` goes to 1 and `mon_byte` goes to all ones. On the second inactive frame tick `done` pulses for one cycle.
- R7: If `ack_n` is still 1 on the tick after a later byte's pre-acknowledge, `aborted` pulses for one cycle, `en_n` goes to 1, `mon_byte` goes to all ones, the block returns to IDLE, and no further byte is consumed.
- R8: `in_ready` is 1 during a frame-tick cycle only when a byte can be taken. That happens in IDLE with the quiet condition of R2, or in ADVANCE once the held byte, not marked last, has been shown two frames. A byte is consumed when `in_valid` and `in_ready` are both 1. `in_last` marks the final byte.
- R9: After the first byte's pre-acknowledge, a return of `ack_n` to 1 never produces `aborted`.
- R10: While the next byte is not valid, the held byte is repeated with `en_n` = 0 and nothing is consumed. Once the byte becomes valid it is announced as in R5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| frame_tick | input | 1 | One-cycle strobe per frame; acknowledge is sampled and outputs update here |
| ack_n | input | 1 | Receiver acknowledge bit, active low |
| in_data | input | DATA_W | Byte offered by the source |
| in_valid | input | 1 | Source has a byte |
| in_last | input | 1 | Offered byte is the last of the message |
| in_ready | output | 1 | Block takes the offered byte in this cycle |
| mon_byte | output | DATA_W | Byte presented this frame, bit DATA_W-1 sent first |
| en_n | output | 1 | Enable bit, active low |
| done | output | 1 | One-cycle pulse when a message has ended normally |
| aborted | output | 1 | One-cycle pulse when the receiver aborted the message |

## Verification
The acknowledge patterns are chosen so that each one separates a pair of behaviours that are easy to confuse. A receiver that pre-acknowledges after a single frame shows whether the minimum repeat is enforced separately from the acknowledge edge. A receiver that stays busy and then goes quiet for one frame and then two shows whether the start gate counts consecutive quiet frames. A two-byte message with a normal acknowledge tells apart the falling pre-acknowledge of the first byte from the rising one of later bytes, and it exposes the one-frame enable gap and the end sequence. An acknowledge that stays high, given once after a later byte and once after the first byte, separates a true abort from the case where no abort is allowed. A source that withholds its second byte shows that repetition does not consume input.

// File: rtl/mon_tx_pkg.sv
package mon_tx_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FIRST,
        ST_ADVANCE,
        ST_GAP,
        ST_HOLD,
        ST_CHECK,
        ST_ENDING
    } mon_tx_state_e;

endpackage

// File: rtl/mon_tx_ack_watch.sv
module mon_tx_ack_watch #(
    parameter int IDLE_FRAMES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic frame_tick,
    input  logic ack_n,
    output logic pre_fall,
    output logic pre_rise,
    output logic idle_ok
);
    localparam int CW = $clog2(IDLE_FRAMES + 1);

    logic          prev_q;
    logic [CW-1:0] run_q;

    // Previous frame's acknowledge and the run of quiet frames before this one.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q <= 1'b1;
            run_q  <= '0;
        end else if (frame_tick) begin
            prev_q <= ack_n;
            if (!ack_n)
                run_q <= '0;
            else if (run_q != CW'(IDLE_FRAMES))
                run_q <= run_q + CW'(1);
        end
    end

    assign pre_fall = frame_tick && prev_q && !ack_n;
    assign pre_rise = frame_tick && !prev_q && ack_n;
    assign idle_ok  = frame_tick && ack_n && (run_q >= CW'(IDLE_FRAMES - 1));

    p_run_bounded_r2: assert property (@(posedge clk) disable iff (!rst_n)
        run_q <= CW'(IDLE_FRAMES));

    p_low_clears_run_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_tick && !ack_n) |=> (run_q == '0));

endmodule

// File: rtl/mon_tx_hold_count.sv
module mon_tx_hold_count #(
    parameter int MIN_REPEAT = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic frame_tick,
    input  logic load,
    output logic shown_ok
);
    localparam int CW = $clog2(MIN_REPEAT + 1);

    logic [CW-1:0] cnt_q;

    // Frames the current byte has occupied, saturating at the minimum.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (load)
            cnt_q <= CW'(1);
        else if (frame_tick && (cnt_q < CW'(MIN_REPEAT)))
            cnt_q <= cnt_q + CW'(1);
    end

    assign shown_ok = (cnt_q >= CW'(MIN_REPEAT));

    p_count_sat_r3: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CW'(MIN_REPEAT));

    p_load_restart_r3: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (cnt_q == CW'(1)));

endmodule

// File: rtl/mon_tx.sv
module mon_tx
    import mon_tx_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int MIN_REPEAT  = 2,
    parameter int IDLE_FRAMES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_tick,
    input  logic              ack_n,
    input  logic [DATA_W-1:0] in_data,
    input  logic              in_valid,
    input  logic              in_last,
    output logic              in_ready,
    output logic [DATA_W-1:0] mon_byte,
    output logic              en_n,
    output logic              done,
    output logic              aborted
);
    localparam logic [DATA_W-1:0] QUIET_BYTE = '1;

    mon_tx_state_e st_q, st_d;
    logic          pre_fall, pre_rise, idle_ok, shown_ok;
    logic          take;
    logic          cur_last_q;

    mon_tx_ack_watch #(.IDLE_FRAMES(IDLE_FRAMES)) u_ack (
        .clk        (clk),
        .rst_n      (rst_n),
        .frame_tick (frame_tick),
        .ack_n      (ack_n),
        .pre_fall   (pre_fall),
        .pre_rise   (pre_rise),
        .idle_ok    (idle_ok)
    );

    mon_tx_hold_count #(.MIN_REPEAT(MIN_REPEAT)) u_hold (
        .clk        (clk),
        .rst_n      (rst_n),
        .frame_tick (frame_tick),
        .load       (take),
        .shown_ok   (shown_ok)
    );

    // A byte can be taken at the start of a message or once the held byte is released.
    assign in_ready = frame_tick &&
                      (((st_q == ST_IDLE) && idle_ok) ||
                       ((st_q == ST_ADVANCE) && shown_ok && !cur_last_q));
    assign take     = in_ready && in_valid;

    // Next-state decision, evaluated only on the frame strobe.
    always_comb begin
        st_d = st_q;
        if (frame_tick) begin
            unique case (st_q)
                ST_IDLE:    if (take) st_d = ST_FIRST;
                ST_FIRST:   if (pre_fall) st_d = ST_ADVANCE;
                ST_ADVANCE: begin
                    if (shown_ok) begin
                        if (cur_last_q)
                            st_d = ST_ENDING;
                        else if (take)
                            st_d = ST_GAP;
                    end
                end
                ST_GAP:     st_d = ST_HOLD;
                ST_HOLD:    if (pre_rise) st_d = ST_CHECK;
                ST_CHECK:   st_d = ack_n ? ST_IDLE : ST_ADVANCE;
                ST_ENDING:  st_d = ST_IDLE;
                default:    st_d = ST_IDLE;
            endcase
        end
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st_q <= ST_IDLE;
        else
            st_q <= st_d;
    end

    // Registered channel outputs and status pulses.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_n       <= 1'b1;
            mon_byte   <= QUIET_BYTE;
            cur_last_q <= 1'b0;
            done       <= 1'b0;
            aborted    <= 1'b0;
        end else begin
            done    <= frame_tick && (st_q == ST_ENDING);
            aborted <= frame_tick && (st_q == ST_CHECK) && ack_n;
            if (take) begin
                mon_byte   <= in_data;
                cur_last_q <= in_last;
            end else if (frame_tick && ((st_d == ST_IDLE) || (st_d == ST_ENDING))) begin
                mon_byte   <= QUIET_BYTE;
            end
            if (frame_tick)
                en_n <= !(st_d inside {ST_FIRST, ST_ADVANCE, ST_HOLD, ST_CHECK});
        end
    end

    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_IDLE) |-> en_n);

    p_ready_on_tick_r8: assert property (@(posedge clk) disable iff (!rst_n)
        in_ready |-> frame_tick);

    p_gap_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_tick && (st_q == ST_GAP)) |=> !en_n);

    p_done_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (en_n && (st_q == ST_IDLE)));

    p_abort_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        aborted |-> (en_n && (st_q == ST_IDLE) && (mon_byte == QUIET_BYTE)));

    p_pulse_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && aborted));

endmodule

// File: tb/mon_tx_tb.sv
`timescale 1ns/1ps
module mon_tx_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       frame_tick = 1'b0;
    logic       ack_n = 1'b1;
    logic [7:0] in_data = 8'h00;
    logic       in_valid = 1'b0;
    logic       in_last = 1'b0;
    logic       in_ready;
    logic [7:0] mon_byte;
    logic       en_n;
    logic       done;
    logic       aborted;

    int n_tests = 0;
    int n_fail  = 0;

    logic [7:0] msg [8];
    int         mlen = 0;
    int         idx  = 0;
    bit         src_on = 1'b0;

    logic       o_ready, o_en, o_done, o_abort;
    logic [7:0] o_byte;

    always #2 clk = ~clk;

    mon_tx u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .frame_tick (frame_tick),
        .ack_n      (ack_n),
        .in_data    (in_data),
        .in_valid   (in_valid),
        .in_last    (in_last),
        .in_ready   (in_ready),
        .mon_byte   (mon_byte),
        .en_n       (en_n),
        .done       (done),
        .aborted    (aborted)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0; frame_tick = 1'b0; ack_n = 1'b1;
        in_valid = 1'b0; src_on = 1'b0; idx = 0; mlen = 0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(posedge clk); #1;
    endtask

    // One frame: present ack and source, strobe, then sample outputs after the edge.
    task automatic frame(input logic a);
        bit took;
        ack_n    = a;
        in_valid = src_on && (idx < mlen);
        in_data  = (idx < mlen) ? msg[idx] : 8'h00;
        in_last  = (idx == mlen - 1);
        frame_tick = 1'b1;
        #1;
        o_ready = in_ready;
        took    = in_ready && in_valid;
        @(posedge clk); #1;
        frame_tick = 1'b0;
        if (took) idx++;
        o_en = en_n; o_byte = mon_byte; o_done = done; o_abort = aborted;
        repeat (3) @(posedge clk);
        #1;
    endtask

    task automatic t_reset();
        do_reset();
        chk("R1 en_n", en_n, 1);
        chk("R1 mon_byte", mon_byte, 8'hFF);
        chk("R1 in_ready", in_ready, 0);
        chk("R1 done", done, 0);
        chk("R1 aborted", aborted, 0);
    endtask

    task automatic t_start_gate();
        do_reset();
        msg[0] = 8'h5A; mlen = 1; src_on = 1'b1;
        frame(1'b0);
        chk("R2 busy no start", o_en, 1);
        frame(1'b1);
        chk("R2 one quiet frame no start", o_en, 1);
        chk("R2 nothing consumed", idx, 0);
        frame(1'b1);
        chk("R2 start en_n", o_en, 0);
        chk("R2 start byte", o_byte, 8'h5A);
    endtask

    task automatic t_two_byte();
        do_reset();
        msg[0] = 8'hA5; msg[1] = 8'h3C; mlen = 2; src_on = 1'b1;
        frame(1'b1);
        frame(1'b1);
        chk("R2 first byte", o_byte, 8'hA5);
        frame(1'b1);
        chk("R4 first held without pre-ack", o_byte, 8'hA5);
        frame(1'b0);
        chk("R4 first byte pre-ack en_n", o_en, 0);
        frame(1'b0);
        chk("R5 gap en_n high", o_en, 1);
        chk("R5 gap new byte", o_byte, 8'h3C);
        chk("R8 second consumed", idx, 2);
        frame(1'b0);
        chk("R5 en_n low after gap", o_en, 0);
        frame(1'b0);
        chk("R4 later held without rise", o_en, 0);
        frame(1'b1);
        chk("R4 pre-ack keeps byte", o_byte, 8'h3C);
        frame(1'b0);
        chk("R4 acknowledged no abort", o_abort, 0);
        chk("R4 acknowledged en_n", o_en, 0);
        frame(1'b0);
        chk("R6 end en_n high", o_en, 1);
        chk("R6 end quiet byte", o_byte, 8'hFF);
        chk("R6 no early done", o_done, 0);
        frame(1'b0);
        chk("R6 done pulse", o_done, 1);
        chk("R6 en_n stays high", o_en, 1);
        chk("R6 done one cycle", done, 0);
    endtask

    task automatic t_abort();
        do_reset();
        msg[0] = 8'h11; msg[1] = 8'h22; msg[2] = 8'h33; mlen = 3; src_on = 1'b1;
        frame(1'b1);
        frame(1'b1);
        frame(1'b0);
        chk("R3 byte kept after early pre-ack", o_byte, 8'h11);
        frame(1'b0);
        chk("R3 change after two frames", o_byte, 8'h22);
        frame(1'b0);
        frame(1'b1);
        chk("R7 pre-ack no abort yet", o_abort, 0);
        frame(1'b1);
        chk("R7 aborted pulse", o_abort, 1);
        chk("R7 en_n high", o_en, 1);
        chk("R7 quiet byte", o_byte, 8'hFF);
        chk("R7 third byte not consumed", idx, 2);
        chk("R7 aborted one cycle", aborted, 0);
        src_on = 1'b0;
        frame(1'b1);
        chk("R7 stays idle", o_en, 1);
    endtask

    task automatic t_first_no_abort();
        do_reset();
        msg[0] = 8'h7E; mlen = 1; src_on = 1'b1;
        frame(1'b1);
        frame(1'b1);
        frame(1'b1);
        frame(1'b0);
        frame(1'b1);
        chk("R9 no abort on first byte", o_abort, 0);
        chk("R9 end begins", o_en, 1);
        frame(1'b1);
        chk("R9 done not abort", o_done, 1);
        chk("R9 aborted low", o_abort, 0);
    endtask

    task automatic t_stall();
        do_reset();
        msg[0] = 8'hC3; msg[1] = 8'h96; mlen = 2; src_on = 1'b1;
        frame(1'b1);
        frame(1'b1);
        src_on = 1'b0;
        frame(1'b0);
        frame(1'b0);
        chk("R8 ready while releasable", o_ready, 1);
        chk("R10 repeat byte", o_byte, 8'hC3);
        chk("R10 en_n low", o_en, 0);
        frame(1'b0);
        chk("R10 still repeating", o_byte, 8'hC3);
        chk("R10 nothing consumed", idx, 1);
        src_on = 1'b1;
        frame(1'b0);
        chk("R10 gap after resume", o_en, 1);
        chk("R10 new byte", o_byte, 8'h96);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        t_reset();
        t_start_gate();
        t_two_byte();
        t_abort();
        t_first_no_abort();
        t_stall();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule